// File: doc/BRIEF.md
# Six-Channel Packed TDM Audio Transmitter

This block serializes six parallel 24-bit audio words onto one data line. Each frame carries three left-group channels followed by three right-group channels. It generates the bit clock itself, as one bit clock period for every two system clock cycles. It also drives a left/right framing clock and the serial data. Two frame layouts are supported. The short layout has 128 bit clocks per frame, with 20-clock slots and two 4-clock gaps. The long layout has 256 bit clocks per frame, with 32-clock slots, a one-clock delay before each MSB, and two 32-clock blank slots. The two layouts drive the framing clock with opposite polarity.

Data and the framing clock change only on the falling edge of the bit clock, so a receiver samples on the rising edge. One cycle before each frame begins, the block raises a one-cycle ready pulse. At the end of that cycle it captures the six words, the layout select and the word-length code. Inputs have no effect at any other time.

Top module: `packed_tdm_tx`

## Requirements
- R1: `bitClk` toggles on every system clock edge. Each bit period is two cycles, low in the first cycle and high in the second.
- R2: Short layout (`longFrame`=0), with positions 0..127 counted from the first falling edge of the frame. Channels 0, 1 and 2 occupy positions 0-19, 20-39 and 40-59. Positions 60-63 are blank. Channels 3, 4 and 5 occupy 64-83, 84-103 and 104-123. Positions 124-127 are blank. Each channel's MSB is at the first position of its slot.
- R3: In the short layout, `frameClk` is 1 for positions 0..63 and 0 for positions 64..127.
- R4: Long layout (`longFrame`=1), with positions 0..255. Slot s covers positions 32*s .. 32*s+31. Slots 0, 1 and 2 carry channels 0, 1 and 2. Slot 3 is blank. Slots 4, 5 and 6 carry channels 3, 4 and 5. Slot 7 is blank. The first position of every slot is 0, and the MSB follows at slot offset 1.
- R5: In the long layout, `frameClk` is 0 for positions 0..127 and 1 for positions 128..255.
- R6: `lenSel` selects the word length: 0 gives 16 bits, 1 gives 20 bits, and 2 or 3 give 24 bits. Channel k is `samples[24*k+23 : 24*k]`. The top L bits of each channel are sent MSB first. `serData` is 0 after the LSB and in all blank positions.
- R7: In the short layout, a 24-bit length is reduced to 20 bits, so the top 20 bits of each channel are sent.
- R8: `serData` and `frameClk` change only on a cycle where `bitClk` falls.
- R9: `ready` is high for exactly one cycle: the low half of the last bit period of each frame. The samples, `longFrame` and `lenSel` are captured at the end of that cycle and take effect at the next position 0. Changes to these inputs at any other time have no effect on the frame.
- R10: During reset, `bitClk`=1, `frameClk`=0, `serData`=0 and `ready`=0. The first `ready` comes in the cycle that follows the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (two cycles per bit clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| longFrame | input | 1 | Layout select: 0 = 128-clock, 1 = 256-clock |
| lenSel | input | 2 | Word length code |
| samples | input | 144 | Six 24-bit channel words, channel k at bits 24k+23..24k |
| bitClk | output | 1 | Generated bit clock |
| frameClk | output | 1 | Left/right framing clock |
| serData | output | 1 | Serial data, MSB first |
| ready | output | 1 | One-cycle request for the next frame's inputs |

## Verification
Every result has a fixed delay from the ready pulse. The inputs are captured at the clock edge that ends the ready cycle. Position 0 begins one edge later. Position k is therefore valid on the falling-edge halves 2+2k and 3+2k counted from the ready cycle.

The bench counts falling system-clock edges from the ready pulse and compares each position in its low half, which is the cycle after the register update. In the high half it checks that nothing has changed. After every capture edge the bench scrambles all inputs, so any capture outside the ready cycle would corrupt the frame it checks.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int WORD_W  = 24;
  localparam int NUM_CH  = 6;
  localparam int POS_W   = 8;                 // counts up to 256 bit periods
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int BIT_W   = $clog2(WORD_W);

  // strobes from control to datapath
  typedef struct packed {
    logic              latch;     // capture inputs at this edge
    logic              advance;   // falling bit clock edge: update serial output
    logic              bitValid;  // the coming position carries a data bit
    logic [CH_W-1:0]   chanIdx;
    logic [BIT_W-1:0]  bitIdx;    // 0 = MSB
  } tdmStrobe_t;
endpackage

// File: rtl/tdm_ctrl.sv
module tdm_ctrl
  import tdm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       longFrame,
  input  logic [1:0] lenSel,
  output tdmStrobe_t strobe,
  output logic       bitClk,
  output logic       frameClk
);
  logic             phase;       // 0: low half, 1: high half
  logic [POS_W-1:0] pos, nPos;
  logic             curMode, pendMode, nMode;
  logic [1:0]       curLen, pendLen, nLen;
  logic             lrReg, nLr, frameEnd;
  logic [5:0]       off;
  logic [5:0]       effLen;
  logic [5:0]       bRel;
  logic [2:0]       chRel;
  logic             active;

  assign frameEnd = (pos[6:0] == 7'h7F) && (!curMode || pos[7]);
  assign nPos     = frameEnd ? '0 : pos + 1'b1;
  assign nMode    = frameEnd ? pendMode : curMode;
  assign nLen     = frameEnd ? pendLen  : curLen;
  assign nLr      = nMode ? nPos[7] : ~nPos[6];

  always_comb begin
    case (nLen)
      2'd0:    effLen = 6'd16;
      2'd1:    effLen = 6'd20;
      default: effLen = 6'd24;
    endcase
    if (!nMode && effLen > 6'd20) effLen = 6'd20;

    off    = {1'b0, nPos[4:0]};
    chRel  = 3'd0;
    bRel   = 6'd0;
    active = 1'b0;
    if (!nMode) begin
      off = nPos[5:0];
      if (off < 6'd20)      begin chRel = 3'd0; bRel = off;          active = 1'b1; end
      else if (off < 6'd40) begin chRel = 3'd1; bRel = off - 6'd20;  active = 1'b1; end
      else if (off < 6'd60) begin chRel = 3'd2; bRel = off - 6'd40;  active = 1'b1; end
      if (nPos[6]) chRel = chRel + 3'd3;
    end else begin
      active = (nPos[6:5] != 2'd3) && (off != 6'd0);
      bRel   = off - 6'd1;
      chRel  = {1'b0, nPos[6:5]} + (nPos[7] ? 3'd3 : 3'd0);
    end
  end

  assign strobe.latch    = !phase && frameEnd;
  assign strobe.advance  = phase;
  assign strobe.bitValid = active && (bRel < effLen);
  assign strobe.chanIdx  = chRel[CH_W-1:0];
  assign strobe.bitIdx   = bRel[BIT_W-1:0];
  assign bitClk          = phase;
  assign frameClk        = lrReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= 1'b1;
      pos      <= 8'hFE;
      curMode  <= 1'b0;
      pendMode <= 1'b0;
      curLen   <= 2'd0;
      pendLen  <= 2'd0;
      lrReg    <= 1'b0;
    end else begin
      phase <= ~phase;
      if (strobe.latch) begin
        pendMode <= longFrame;
        pendLen  <= lenSel;
      end
      if (strobe.advance) begin
        pos     <= nPos;
        curMode <= nMode;
        curLen  <= nLen;
        lrReg   <= nLr;
      end
    end
  end

  // R5
  long_lr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (curMode && !pos[7]) |-> !frameClk);
  // R3
  short_lr_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!curMode && !pos[6]) |-> frameClk);
endmodule

// File: rtl/tdm_datapath.sv
module tdm_datapath
  import tdm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH*WORD_W-1:0] samples,
  input  tdmStrobe_t               strobe,
  output logic                     serData
);
  logic [WORD_W-1:0] wordReg [NUM_CH];
  logic [WORD_W-1:0] selWord;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            wordReg[k] <= '0;
      else if (strobe.latch) wordReg[k] <= samples[k*WORD_W +: WORD_W];
    end
  end

  assign selWord = wordReg[strobe.chanIdx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              serData <= 1'b0;
    else if (strobe.advance) serData <= strobe.bitValid
                                        ? selWord[BIT_W'(WORD_W-1) - strobe.bitIdx] : 1'b0;
  end

  // R9
  latch_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.latch |-> !strobe.advance);
endmodule

// File: rtl/packed_tdm_tx.sv
module packed_tdm_tx
  import tdm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     longFrame,
  input  logic [1:0]               lenSel,
  input  logic [NUM_CH*WORD_W-1:0] samples,
  output logic                     bitClk,
  output logic                     frameClk,
  output logic                     serData,
  output logic                     ready
);
  tdmStrobe_t strobe;

  tdm_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .longFrame(longFrame), .lenSel(lenSel),
    .strobe(strobe), .bitClk(bitClk), .frameClk(frameClk)
  );

  tdm_datapath dp_i (
    .clk(clk), .rst_n(rst_n), .samples(samples), .strobe(strobe), .serData(serData)
  );

  assign ready = strobe.latch;

  // R1
  bclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bitClk != $past(bitClk)));
  // R8
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(serData) |-> $fell(bitClk));
  // R8
  lr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frameClk) |-> $fell(bitClk));
  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  // R9
  ready_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !bitClk);
endmodule

// File: tb/packed_tdm_tx_tb.sv
module packed_tdm_tx_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         longFrame = 1'b0;
  logic [1:0]   lenSel = 2'd0;
  logic [143:0] samples = '0;
  logic         bitClk, frameClk, serData, ready;
  int           errors = 0;
  int           checks = 0;
  bit           done = 1'b0;
  logic [23:0]  expW [6];

  always #5 clk = ~clk;

  packed_tdm_tx dut_i (
    .clk(clk), .rst_n(rst_n), .longFrame(longFrame), .lenSel(lenSel),
    .samples(samples), .bitClk(bitClk), .frameClk(frameClk),
    .serData(serData), .ready(ready)
  );

  function automatic logic expBit(input logic m, input logic [1:0] len, input int k);
    int grp, off, ch, j, lim;
    if (!m) begin
      grp = k / 64; off = k % 64;
      if (off >= 60) return 1'b0;
      ch = grp * 3 + off / 20; j = off % 20;
      lim = (len == 2'd0) ? 16 : 20;
      return (j < lim) ? expW[ch][23-j] : 1'b0;
    end
    grp = k / 128; off = (k % 128) / 32; j = k % 32;
    if (off == 3 || j == 0) return 1'b0;
    ch = grp * 3 + off;
    lim = (len == 2'd0) ? 16 : (len == 2'd1) ? 20 : 24;
    return ((j - 1) < lim) ? expW[ch][24-j] : 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runFrame(input logic m, input logic [1:0] len, input int seed, input string tag);
    int n, badD, badLr, badClk, badRdy, firstK, actD, expD;
    logic lrExp;
    n = m ? 256 : 128;
    badD = 0; badLr = 0; badClk = 0; badRdy = 0; firstK = -1; actD = 0; expD = 0;
    longFrame = m; lenSel = len;
    for (int c = 0; c < 6; c++) begin
      expW[c] = 24'hA5C3F1 ^ 24'(seed * 24'h13579B) ^ 24'(c * 24'h2468AD);
      samples[c*24 +: 24] = expW[c];
    end
    while (!ready) @(negedge clk);
    @(posedge clk); #1;
    samples = ~samples; longFrame = ~m; lenSel = ~len;   // R9 ignored after capture
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);                      // low half of position k
      lrExp = m ? (k >= 128) : (k < 64);
      if (serData !== expBit(m, len, k)) begin
        if (firstK < 0) begin firstK = k; actD = serData; expD = expBit(m, len, k); end
        badD++;
      end
      if (frameClk !== lrExp) badLr++;
      if (bitClk !== 1'b0) badClk++;
      if (ready !== (k == n - 1)) badRdy++;
      if (k == n - 1) break;
      @(negedge clk);                      // high half: nothing may move
      if (bitClk !== 1'b1 || serData !== expBit(m, len, k) || frameClk !== lrExp) badClk++;
      if (ready !== 1'b0) badRdy++;
    end
    check(badD == 0, $sformatf("%s R9 data pos %0d", tag, firstK), actD, expD);
    check(badLr == 0, m ? "R5 frameClk mismatches" : "R3 frameClk mismatches", badLr, 0);
    check(badClk == 0, "R1 R8 bitClk/stability mismatches", badClk, 0);
    check(badRdy == 0, "R9 ready placement mismatches", badRdy, 0);
  endtask

  task automatic resetTest();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(bitClk === 1'b1 && frameClk === 1'b0 && serData === 1'b0 && ready === 1'b0,
          "R10 reset outputs", {bitClk, frameClk, serData, ready}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready === 1'b1, "R10 first ready", ready, 1);
  endtask

  initial begin
    resetTest();
    runFrame(1'b0, 2'd0, 1, "R2 R6 short/16");
    runFrame(1'b0, 2'd1, 2, "R2 R6 short/20");
    runFrame(1'b0, 2'd2, 3, "R7 short/24 clamp");
    runFrame(1'b0, 2'd3, 4, "R7 short/code3 clamp");
    runFrame(1'b1, 2'd0, 5, "R4 R6 long/16");
    runFrame(1'b1, 2'd1, 6, "R4 R6 long/20");
    runFrame(1'b1, 2'd2, 7, "R4 R6 long/24");
    runFrame(1'b0, 2'd1, 8, "R2 back to short");
    runFrame(1'b1, 2'd3, 9, "R4 R6 long/code3");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule